// File: doc/BRIEF.md
# SMBus Clock-Low Timeout Monitor

This block sits beside the target-side serial interface of an SMBus/I2C port. It receives SCL and SDA levels that are already synchronized to the system clock. Both lines pass through a glitch filter, and the filtered lines are then watched for START and STOP conditions. Between a START and the matching STOP, the block measures how long SCL stays low.

If SCL is held low past a configurable limit, the block raises a one-cycle reset pulse for the serial interface logic. It also raises an override that forces the SDA pull-down off. From then on the bus is treated as idle until a fresh START arrives. The filtered lines and the START/STOP strobes are also exported, so the rest of the interface decodes bus conditions from the same cleaned-up signals.

All lengths are in system-clock cycles. At 100 MHz, the default filter of 5 cycles suppresses pulses of 50 ns or shorter. The default limit of 3,000,000 cycles (30 ms) sits in the middle of the 25 to 35 ms window. A 10 kHz bus has low phases of at most about 50 us, so it stays far from the limit.

Top module: `smb_lowtime_guard`

## Requirements
- R1: A change on `scl_i` or `sda_i` reaches its filtered output only after the raw level has differed from the filtered level for FILT_CYC+1 consecutive clock samples. A pulse of FILT_CYC cycles or fewer never appears on the filtered output.
- R2: `start_o` pulses high for one cycle after filtered SDA falls while filtered SCL is high.
- R3: `stop_o` pulses high for one cycle after filtered SDA rises while filtered SCL is high.
- R4: Outside a transaction (before the first START, after a STOP or after a timeout), SCL low for any length of time never raises `tmo_rst_o`.
- R5: Inside a transaction, `tmo_rst_o` pulses once filtered SCL has been sampled low on TMO_CYC consecutive cycles. TMO_CYC defaults to 3,000,000 (30 ms at 100 MHz).
- R6: `tmo_rst_o` is high for exactly one cycle. After it, no further pulse occurs until a new START, even if SCL stays low.
- R7: `sda_release_o` is 0 after reset. It goes to 1 in the same cycle as the timeout pulse and stays at 1 until the next START strobe clears it.
- R8: Any high level on filtered SCL clears the low-time count, so repeated low phases that are each shorter than the limit never cause a timeout.
- R9: A STOP ends the transaction and clears the count.
- R10: A repeated START inside an open transaction keeps it open, so a later overlong low phase still causes a timeout.
- R11: After reset, `scl_f_o` and `sda_f_o` are 1, and `start_o`, `stop_o`, `tmo_rst_o` and `sda_release_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized raw SCL level |
| sda_i | input | 1 | Synchronized raw SDA level |
| scl_f_o | output | 1 | Glitch-filtered SCL |
| sda_f_o | output | 1 | Glitch-filtered SDA |
| start_o | output | 1 | One-cycle START strobe |
| stop_o | output | 1 | One-cycle STOP strobe |
| tmo_rst_o | output | 1 | One-cycle timeout reset for the serial interface |
| sda_release_o | output | 1 | Forces the SDA pull-down off after a timeout |

## Verification
The bench targets the filter boundary: a pulse of exactly FILT_CYC cycles must vanish, while one cycle more must produce a START and a STOP. An off-by-one filter would either let bus noise start a transaction or swallow real edges.

For the timeout it compares a low phase two cycles short of the limit with one just past it. A long low outside a transaction, after a STOP, and continuing after a timeout must all stay silent. A counter armed at the wrong time would reset a healthy interface or fire repeatedly on a stuck bus.

It also checks that the release override holds until a fresh START, and that a repeated START keeps the watch armed. A design that got these wrong would either leave SDA forced off or stop guarding a live transaction.

// File: rtl/smb_guard_pkg.sv
package smb_guard_pkg;
  typedef enum logic {
    XF_IDLE = 1'b0,
    XF_OPEN = 1'b1
  } xfer_state_e;

  localparam int LN_SCL = 0;
  localparam int LN_SDA = 1;
  localparam int LN_NUM = 2;
endpackage

// File: rtl/smb_line_filter.sv
module smb_line_filter #(
  parameter int FILT_CYC = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic clean_o
);
  localparam int CW = $clog2(FILT_CYC + 1) + 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(FILT_CYC);

  logic [CW-1:0] diff_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      clean_o  <= 1'b1;
      diff_cnt <= '0;
    end else if (raw_i != clean_o) begin
      if (diff_cnt == CNT_LAST) begin
        clean_o  <= raw_i;
        diff_cnt <= '0;
      end else begin
        diff_cnt <= diff_cnt + 1'b1;
      end
    end else begin
      diff_cnt <= '0;
    end
  end

  AST_FILT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (clean_o != $past(clean_o)) |-> ($past(raw_i) == clean_o)); // R1
  AST_FILT_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    diff_cnt <= CNT_LAST); // R1
endmodule

// File: rtl/smb_cond_detect.sv
module smb_cond_detect (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic start_o,
  output logic stop_o
);
  logic sda_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sda_prev <= 1'b1;
      start_o  <= 1'b0;
      stop_o   <= 1'b0;
    end else begin
      sda_prev <= sda_f;
      start_o  <= scl_f & sda_prev & ~sda_f;
      stop_o   <= scl_f & ~sda_prev & sda_f;
    end
  end

  AST_NO_BOTH_COND: assert property (@(posedge clk) disable iff (rst)
    !(start_o && stop_o)); // R2
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o); // R2
  AST_STOP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    stop_o |=> !stop_o); // R3
endmodule

// File: rtl/smb_lowtime_timer.sv
module smb_lowtime_timer
  import smb_guard_pkg::*;
#(
  parameter int TMO_CYC = 3_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic start_s,
  input  logic stop_s,
  output logic tmo_rst_o,
  output logic sda_rel_o
);
  localparam int TW = $clog2(TMO_CYC + 1);
  localparam logic [TW-1:0] CNT_LAST = TW'(TMO_CYC - 1);

  xfer_state_e   state;
  logic [TW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= XF_IDLE;
      low_cnt   <= '0;
      tmo_rst_o <= 1'b0;
      sda_rel_o <= 1'b0;
    end else begin
      tmo_rst_o <= 1'b0;
      if (start_s) begin
        state     <= XF_OPEN;
        low_cnt   <= '0;
        sda_rel_o <= 1'b0;
      end else if (stop_s) begin
        state   <= XF_IDLE;
        low_cnt <= '0;
      end else if (state == XF_OPEN) begin
        if (scl_f) begin
          low_cnt <= '0;
        end else if (low_cnt == CNT_LAST) begin
          tmo_rst_o <= 1'b1;
          sda_rel_o <= 1'b1;
          state     <= XF_IDLE;
          low_cnt   <= '0;
        end else begin
          low_cnt <= low_cnt + 1'b1;
        end
      end else begin
        low_cnt <= '0;
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    low_cnt <= CNT_LAST); // R5
  AST_TMO_ONLY_OPEN: assert property (@(posedge clk) disable iff (rst)
    tmo_rst_o |-> ($past(state) == XF_OPEN)); // R4
  AST_TMO_SINGLE: assert property (@(posedge clk) disable iff (rst)
    tmo_rst_o |=> !tmo_rst_o); // R6
  AST_REL_SET_BY_TMO: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_rel_o) |-> tmo_rst_o); // R7
  AST_REL_CLR_BY_START: assert property (@(posedge clk) disable iff (rst)
    $fell(sda_rel_o) |-> $past(start_s)); // R7
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (stop_s && !start_s) |=> (low_cnt == '0)); // R9
endmodule

// File: rtl/smb_lowtime_guard.sv
module smb_lowtime_guard
  import smb_guard_pkg::*;
#(
  parameter int FILT_CYC = 5,
  parameter int TMO_CYC  = 3_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_f_o,
  output logic sda_f_o,
  output logic start_o,
  output logic stop_o,
  output logic tmo_rst_o,
  output logic sda_release_o
);
  logic [LN_NUM-1:0] raw_lines;
  logic [LN_NUM-1:0] clean_lines;

  assign raw_lines[LN_SCL] = scl_i;
  assign raw_lines[LN_SDA] = sda_i;

  for (genvar g = 0; g < LN_NUM; g++) begin : g_filt
    smb_line_filter #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk    (clk),
      .rst    (rst),
      .raw_i  (raw_lines[g]),
      .clean_o(clean_lines[g])
    );
  end

  assign scl_f_o = clean_lines[LN_SCL];
  assign sda_f_o = clean_lines[LN_SDA];

  smb_cond_detect u_det (
    .clk    (clk),
    .rst    (rst),
    .scl_f  (clean_lines[LN_SCL]),
    .sda_f  (clean_lines[LN_SDA]),
    .start_o(start_o),
    .stop_o (stop_o)
  );

  smb_lowtime_timer #(.TMO_CYC(TMO_CYC)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .scl_f    (clean_lines[LN_SCL]),
    .start_s  (start_o),
    .stop_s   (stop_o),
    .tmo_rst_o(tmo_rst_o),
    .sda_rel_o(sda_release_o)
  );

  AST_TMO_NEEDS_LOW: assert property (@(posedge clk) disable iff (rst)
    tmo_rst_o |-> $past(!scl_f_o)); // R8
endmodule

// File: tb/tb_smb_lowtime_guard.sv
module tb_smb_lowtime_guard;
  localparam int FILT = 4;
  localparam int TMO  = 200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda = 1'b1;
  logic scl_f, sda_f, start_s, stop_s, tmo_s, rel_s;

  int checks = 0;
  int errors = 0;
  int n_start = 0, n_stop = 0, n_tmo = 0, n_sda_fall = 0;
  int tmo_run = 0, tmo_max = 0;

  always #5 clk = ~clk;

  smb_lowtime_guard #(.FILT_CYC(FILT), .TMO_CYC(TMO)) dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda),
    .scl_f_o(scl_f), .sda_f_o(sda_f), .start_o(start_s), .stop_o(stop_s),
    .tmo_rst_o(tmo_s), .sda_release_o(rel_s)
  );

  logic sda_f_q = 1'b1;
  always @(posedge clk) begin
    if (!rst) begin
      if (start_s) n_start++;
      if (stop_s) n_stop++;
      if (tmo_s) begin
        n_tmo++;
        tmo_run++;
        if (tmo_run > tmo_max) tmo_max = tmo_run;
      end else tmo_run = 0;
      if (sda_f_q && !sda_f) n_sda_fall++;
    end
    sda_f_q = sda_f;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    scl = 1'b1; sda = 1'b1; rst = 1'b1;
    hold(3);
    rst = 1'b0;
    hold(2);
  endtask

  task automatic do_start();
    scl = 1'b1; hold(20);
    sda = 1'b1; hold(20);
    sda = 1'b0; hold(20);
    scl = 1'b0; hold(20);
  endtask

  task automatic do_stop();
    scl = 1'b0; hold(10);
    sda = 1'b0; hold(20);
    scl = 1'b1; hold(20);
    sda = 1'b1; hold(20);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; scl = 1'b1; sda = 1'b1;
    hold(3);
    check("R11 scl_f after reset", scl_f, 1);
    check("R11 sda_f after reset", sda_f, 1);
    check("R11 strobes after reset", start_s | stop_s | tmo_s, 0);
    check("R11 release after reset", rel_s, 0);
    rst = 1'b0;
    hold(2);
  endtask

  task automatic t_glitch();
    int s0, p0, f0;
    do_reset();
    s0 = n_start; p0 = n_stop; f0 = n_sda_fall;
    sda = 1'b0; hold(FILT); sda = 1'b1; hold(20);
    check("R1 short sda pulse suppressed", n_sda_fall - f0, 0);
    check("R1 short pulse gives no START", n_start - s0, 0);
    scl = 1'b0; hold(FILT); scl = 1'b1; hold(20);
    check("R1 short scl pulse suppressed", scl_f, 1);
    sda = 1'b0; hold(FILT + 1); sda = 1'b1; hold(20);
    check("R1 R2 pulse of FILT+1 gives START", n_start - s0, 1);
    check("R3 rising sda gives STOP", n_stop - p0, 1);
  endtask

  task automatic t_start_stop();
    int s0, p0;
    do_reset();
    s0 = n_start; p0 = n_stop;
    do_start();
    check("R2 START counted", n_start - s0, 1);
    check("R3 no STOP during START", n_stop - p0, 0);
    do_stop();
    check("R3 STOP counted", n_stop - p0, 1);
  endtask

  task automatic t_idle_low();
    int t0;
    do_reset();
    t0 = n_tmo;
    scl = 1'b0; hold(3 * TMO); scl = 1'b1; hold(20);
    check("R4 no timeout outside transaction", n_tmo - t0, 0);
  endtask

  task automatic t_short_lows();
    int t0;
    do_reset();
    t0 = n_tmo;
    do_start();
    scl = 1'b1; hold(20);
    for (int i = 0; i < 5; i++) begin
      scl = 1'b0; hold(TMO - 2);
      scl = 1'b1; hold(20);
    end
    check("R8 R5 lows of TMO-2 never time out", n_tmo - t0, 0);
    do_stop();
  endtask

  task automatic t_timeout();
    int t0, s0;
    do_reset();
    t0 = n_tmo;
    do_start();
    check("R7 release low before timeout", rel_s, 0);
    scl = 1'b1; hold(20);
    scl = 1'b0; hold(TMO + 10);
    check("R5 timeout after TMO low cycles", n_tmo - t0, 1);
    check("R6 timeout pulse one cycle wide", tmo_max, 1);
    check("R7 release set by timeout", rel_s, 1);
    hold(3 * TMO);
    check("R6 no second pulse while low", n_tmo - t0, 1);
    check("R7 release held until START", rel_s, 1);
    s0 = n_start;
    scl = 1'b1; hold(20);
    sda = 1'b1; hold(20);
    sda = 1'b0; hold(20);
    check("R7 fresh START seen", n_start - s0, 1);
    check("R7 release cleared by START", rel_s, 0);
    do_stop();
  endtask

  task automatic t_stop_closes();
    int t0;
    do_reset();
    t0 = n_tmo;
    do_start();
    do_stop();
    scl = 1'b0; hold(3 * TMO); scl = 1'b1; hold(20);
    check("R9 no timeout after STOP", n_tmo - t0, 0);
  endtask

  task automatic t_restart();
    int t0, s0;
    do_reset();
    t0 = n_tmo; s0 = n_start;
    do_start();
    hold(50);
    sda = 1'b1; hold(20);
    scl = 1'b1; hold(20);
    sda = 1'b0; hold(20);
    scl = 1'b0; hold(TMO + 10);
    check("R10 repeated START counted", n_start - s0, 2);
    check("R10 timeout after repeated START", n_tmo - t0, 1);
  endtask

  initial begin
    t_reset();
    t_glitch();
    t_start_stop();
    t_idle_low();
    t_short_lows();
    t_timeout();
    t_stop_closes();
    t_restart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule